// File: doc/BRIEF.md
# Piecewise Fractional Pixel-Clock Enable Divider

This block derives a pixel-clock enable for a display interface from a fast source clock. Software writes a 7-bit ratio code into a 16-bit control register. The code selects a fractional divide ratio from a three-segment map. Low codes step the divisor in quarters, the middle codes step it in halves, and the top codes step it in whole units. The block does not generate a new clock. It produces a one-cycle enable pulse train whose long-run rate is the source rate divided by the selected divisor.

Fractional ratios come from a phase accumulator that counts in quarter units. Each pulse is therefore spaced by either the floor or the ceiling of the divisor, and the average spacing is exact. A source-select input marks the source as running at half rate, and every resulting rate halves. While the PLL-enabled qualifier is low, the code is ignored and the enable stays high on every cycle. A code change waits for the next pulse, so no period is cut short or stretched.

Top module: `pixdiv_top`

## Requirements
- R1: Codes 0 to 64 give a divisor of 1 + code/4 (code 0 gives 1, code 1 gives 1.25, code 3 gives 1.75, code 64 gives 17). With full rate selected, the pulse count over a window of W cycles is within one of W/divisor.
- R2: Codes 64 to 96 give a divisor of 17 + (code − 64)/2 (code 65 gives 17.5, code 95 gives 32.5, code 96 gives 33). The pulse count over a window is within one of the ideal value.
- R3: Codes 96 to 127 give a divisor of 33 + (code − 96) (code 97 gives 34, code 127 gives 64). The pulse count over a window is within one of the ideal value.
- R4: With `half_rate` = 1 and `pll_on` = 1, every pulse rate is half its full-rate value. No two pulses are ever adjacent.
- R5: While `pll_on` = 0, `pix_en` is 1 on every cycle that follows a cycle with `pll_on` low. This holds whatever the code or `half_rate` is.
- R6: The control register is 16 bits wide. Bits 15:9 hold the code and can be read back. Bits 8:0 always read 0, whatever is written to them. Reset clears the register to 0 and clears `pix_en`.
- R7: A code written in mid-period takes effect only at the next pulse, and the period in progress keeps the old divisor. A write that lands on the same edge as a pulse is not picked up until the following pulse.
- R8: For a fractional divisor D, each interval between consecutive pulses is either floor(D) or ceil(D) cycles at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write data; bits 15:9 carry the ratio code |
| rd_data | output | 16 | Control register read-back; bits 8:0 are zero |
| half_rate | input | 1 | 1 when the source runs at half rate; halves all output rates |
| pll_on | input | 1 | PLL-enabled qualifier; when 0, the code is ignored and the enable is constant |
| pix_en | output | 1 | Registered pixel-clock enable pulse |

## Verification
Two events can fall on the same source edge: a control register write and the pulse boundary at which the active divisor is reloaded. The bench runs the slowest code, which has a 64-cycle period. It places one write in the middle of a period. It places a second write on exactly the edge that produces a pulse, and then measures the following intervals. The mid-period write must show its new divisor one interval later. The coincident write must leave one more full 64-cycle interval before the new divisor appears.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;
  // Divisor is carried in quarter units of the source period.
  localparam int unsigned CODE_W   = 7;
  localparam int unsigned DIV_W    = 9;
  localparam int unsigned SEG1_END = 64;
  localparam int unsigned SEG2_END = 96;
  localparam int unsigned Q_FULL   = 4;
  localparam int unsigned Q_HALF   = 2;
endpackage

// File: rtl/pixdiv_ctrl_reg.sv
module pixdiv_ctrl_reg #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned CODE_LSB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst)        code <= '0;
    else if (wr_en) code <= wr_data[CODE_MSB:CODE_LSB];
  end

  // Only the code field is implemented; every other bit reads back as zero.
  always_comb begin
    rd_data = '0;
    rd_data[CODE_MSB:CODE_LSB] = code;
  end
endmodule

// File: rtl/pixdiv_map.sv
module pixdiv_map
  import pixdiv_pkg::*;
#(
  parameter int unsigned CW = CODE_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic [CW-1:0] code,
  output logic [DW-1:0] div_q
);
  localparam logic [DW-1:0] BASE2 = DW'(Q_FULL + SEG1_END);
  localparam logic [DW-1:0] BASE3 = DW'(Q_FULL + SEG1_END + 2*(SEG2_END - SEG1_END));

  logic [DW-1:0] c_ext;
  assign c_ext = DW'(code);

  always_comb begin
    if (c_ext <= DW'(SEG1_END))
      div_q = DW'(Q_FULL) + c_ext;                          // quarter steps
    else if (c_ext <= DW'(SEG2_END))
      div_q = BASE2 + ((c_ext - DW'(SEG1_END)) << 1);       // half steps
    else
      div_q = BASE3 + ((c_ext - DW'(SEG2_END)) << 2);       // whole steps
  end
endmodule

// File: rtl/pixdiv_phase.sv
module pixdiv_phase
  import pixdiv_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          half,
  input  logic [DW-1:0] div_in,
  output logic          pix_en
);
  localparam int unsigned AW = DW + 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;
  logic [DW-1:0] div_act;
  logic          fire;

  always_comb begin
    sum  = acc_q + (half ? AW'(Q_HALF) : AW'(Q_FULL));
    fire = (sum >= AW'(div_act));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      div_act <= DW'(Q_FULL);
      pix_en  <= 1'b0;
    end else if (!run) begin
      acc_q   <= '0;
      div_act <= div_in;
      pix_en  <= 1'b1;
    end else begin
      pix_en <= fire;
      if (fire) begin
        acc_q   <= sum - AW'(div_act);
        div_act <= div_in;   // reload only on a pulse boundary
      end else begin
        acc_q   <= sum;
      end
    end
  end
endmodule

// File: rtl/pixdiv_top.sv
module pixdiv_top
  import pixdiv_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned CODE_LSB = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             half_rate,
  input  logic             pll_on,
  output logic             pix_en
);
  logic [CODE_W-1:0] code;
  logic [DIV_W-1:0]  div_q;

  pixdiv_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .code(code), .rd_data(rd_data)
  );

  pixdiv_map #(.CW(CODE_W), .DW(DIV_W)) u_map (
    .code(code), .div_q(div_q)
  );

  pixdiv_phase #(.DW(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .run(pll_on), .half(half_rate),
    .div_in(div_q), .pix_en(pix_en)
  );
endmodule

// File: rtl/pixdiv_chk.sv
module pixdiv_chk #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned CODE_LSB = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             half_rate,
  input logic             pll_on,
  input logic             pix_en
);
  p_reset_state_r6: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !pix_en);

  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[CODE_LSB-1:0] == '0);

  p_write_readback_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[REG_W-1:CODE_LSB] == $past(wr_data[REG_W-1:CODE_LSB]));

  p_pll_off_const_r5: assert property (@(posedge clk) disable iff (rst)
    !pll_on |=> pix_en);

  p_half_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (pll_on && $past(pll_on) && half_rate && $past(half_rate) && pix_en) |=> !pix_en);
endmodule

bind pixdiv_top pixdiv_chk #(.REG_W(REG_W), .CODE_LSB(CODE_LSB)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .half_rate(half_rate), .pll_on(pll_on), .pix_en(pix_en)
);

// File: tb/sim_pixdiv_top.sv
`timescale 1ns/1ps
module sim_pixdiv_top;
  localparam int WIN = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        half_rate = 1'b0;
  logic        pll_on = 1'b0;
  logic        pix_en;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  pixdiv_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .half_rate(half_rate), .pll_on(pll_on), .pix_en(pix_en)
  );

  // Divisor in quarter cycles, taken straight from the segment formulas.
  function automatic int ref_q(input int c);
    if (c <= 64)      return 4 + c;
    else if (c <= 96) return 68 + 2 * (c - 64);
    else              return 132 + 4 * (c - 96);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_code(input int c);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {c[6:0], 9'h1FF};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Stop the divider, load a code, then restart it with a cleared phase.
  task automatic restart(input int c, input bit h);
    pll_on = 1'b0;
    write_code(c);
    half_rate = h;
    repeat (3) @(negedge clk);
    pll_on = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_data == 16'h0, "R6 reset reg", int'(rd_data), 0);
    check(pix_en == 1'b0, "R6 reset pix_en", int'(pix_en), 0);
    rst = 1'b0;
  endtask

  task automatic t_regs();
    write_code(7'h55);
    check(rd_data == 16'hAA00, "R6 readback", int'(rd_data), 16'hAA00);
    write_code(7'h7F);
    check(rd_data[8:0] == 9'h0, "R6 low bits zero", int'(rd_data[8:0]), 0);
    check(rd_data[15:9] == 7'h7F, "R6 code field", int'(rd_data[15:9]), 127);
  endtask

  task automatic t_rate(input int c, input bit h, input string req);
    int cnt = 0;
    int exp;
    restart(c, h);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (pix_en) cnt++;
    end
    exp = WIN * (h ? 2 : 4) / ref_q(c);
    check((cnt >= exp - 1) && (cnt <= exp + 1), req, cnt, exp);
  endtask

  task automatic t_pll_off();
    int cnt = 0;
    write_code(127);
    half_rate = 1'b1;
    pll_on = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pix_en) cnt++;
    end
    check(cnt == 50, "R5 pll off, half rate", cnt, 50);
    half_rate = 1'b0;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pix_en) cnt++;
    end
    check(cnt == 50, "R5 pll off, full rate", cnt, 50);
  endtask

  task automatic t_jitter(input int c);
    int q = ref_q(c);
    int lo = q / 4;
    int hi = (q + 3) / 4;
    int g;
    restart(c, 1'b0);
    do @(negedge clk); while (!pix_en);
    for (int k = 0; k < 8; k++) begin
      g = 0;
      do begin @(negedge clk); g++; end while (!pix_en);
      check((g == lo) || (g == hi), "R8 interval", g, hi);
    end
  endtask

  // Counts the interval to the next pulse; a write of code wc is driven so
  // that it is sampled on the edge after negedge number gw.
  task automatic gap_with_write(input int gw, input int wc, output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == gw) begin wr_en = 1'b1; wr_data = {wc[6:0], 9'h0}; end
      else wr_en = 1'b0;
    end while (!pix_en);
    wr_en = 1'b0;
  endtask

  task automatic t_boundary();
    int g;
    restart(127, 1'b0);
    do @(negedge clk); while (!pix_en);
    gap_with_write(10, 0, g);
    check(g == 64, "R7 mid-period write keeps period", g, 64);
    gap_with_write(0, 0, g);
    check(g == 1, "R7 new code after boundary", g, 1);
    restart(127, 1'b0);
    do @(negedge clk); while (!pix_en);
    gap_with_write(63, 0, g);   // write lands on the pulse edge
    check(g == 64, "R7 coincident write, first interval", g, 64);
    gap_with_write(0, 0, g);
    check(g == 64, "R7 coincident write, old divisor kept", g, 64);
    gap_with_write(0, 0, g);
    check(g == 1, "R7 coincident write, then applied", g, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_pll_off();
    t_rate(0,   1'b0, "R1 code 0");
    t_rate(1,   1'b0, "R1 code 1");
    t_rate(2,   1'b0, "R1 code 2");
    t_rate(3,   1'b0, "R1 code 3");
    t_rate(64,  1'b0, "R1 code 64");
    t_rate(65,  1'b0, "R2 code 65");
    t_rate(95,  1'b0, "R2 code 95");
    t_rate(96,  1'b0, "R2 code 96");
    t_rate(97,  1'b0, "R3 code 97");
    t_rate(127, 1'b0, "R3 code 127");
    t_rate(0,   1'b1, "R4 half code 0");
    t_rate(2,   1'b1, "R4 half code 2");
    t_rate(127, 1'b1, "R4 half code 127");
    t_jitter(1);
    t_jitter(2);
    t_jitter(65);
    t_boundary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule